// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block listens to the command pins of a DDR SDRAM-style memory bus on the device side. On every rising clock edge it samples chip-select, the row strobe, the column strobe, write-enable, clock-enable, the bank address and the address bus. From these it works out which command was issued. It keeps the state of every bank and reports each command it carries out as a one-cycle strobe, together with the bank and the row or column it targets. It stores the two mode-register opcodes and follows the power mode that clock-enable selects.

Each bank is a small state machine with three states: `BK_IDLE`, `BK_OPEN` and `BK_CLOSING`. The transitions are:
- open on ACTIVE: IDLE→OPEN
- close on PRECHARGE: OPEN→IDLE
- schedule auto precharge on READ or WRITE with the auto-precharge bit set: OPEN→CLOSING
- unconditional retire: CLOSING→IDLE

The power machine has four states: `PW_RUN`, `PW_PRE_PD`, `PW_ACT_PD` and `PW_SELF`. The transitions are:
- clock-enable falls with every bank idle: RUN→PRE_PD
- clock-enable falls with any bank open or closing: RUN→ACT_PD
- clock-enable falls together with REFRESH and every bank idle: RUN→SELF
- exit on the first edge that samples clock-enable high: any low-power state→RUN

Commands that break the protocol are not carried out, and an error flag is raised for them. There are two flags: a protocol error and a clock-enable error. All outputs are registered, so a command sampled on edge k shows at the outputs right after edge k.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n is sampled high, no command strobe, error flag or mode-register change results, whatever the other control pins hold.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 mode load, 110 burst stop. An executed command raises only its own strobe for exactly one cycle.
- R3: An ACTIVE to an idle bank, selected by ba, marks that bank active, stores addr as its open row on open_rows[ba*12 +: 12], and reports ba and addr on tgt_bank and tgt_addr.
- R4: For PRECHARGE, addr[10] low closes only bank ba. With addr[10] high, every bank closes and pre_all pulses.
- R5: A READ or WRITE to an open bank with addr[10] high pulses auto_pre. Its bank stays active for one more cycle and is idle after the following edge.
- R6: A mode load with ba=0 stores addr in mode_reg, and with ba=1 stores it in ext_mode_reg. Other ba values store nothing.
- R7: When cke is sampled low in run mode with every bank idle, pwr_mode becomes 1 (precharge power-down). With any bank open or closing, it becomes 2 (active power-down).
- R8: REFRESH on the edge where cke falls enters self refresh (pwr_mode 3) only when every bank is idle. Otherwise proto_err pulses and active power-down is entered.
- R9: A READ or WRITE sampled with cke low, whether on the falling edge or during a low-power mode, pulses cke_err and is not carried out.
- R10: ACTIVE to an active bank, and READ or WRITE to an idle bank, pulse proto_err and leave the bank state unchanged.
- R11: From any low-power mode, the first edge with cke high returns pwr_mode to 0, and no command is decoded on that edge.
- R12: After reset all banks are idle, pwr_mode is 0, both mode registers are zero and all strobes and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address / mode-register select |
| addr | input | 12 | Row, column or opcode; bit 10 is the precharge modifier |
| cmd_act | output | 1 | ACTIVE executed |
| cmd_rd | output | 1 | READ executed |
| cmd_wr | output | 1 | WRITE executed |
| cmd_pre | output | 1 | PRECHARGE executed |
| cmd_ref | output | 1 | REFRESH executed (auto or self) |
| cmd_mrs | output | 1 | Mode load executed |
| cmd_bst | output | 1 | Burst stop executed |
| pre_all | output | 1 | The precharge applied to all banks |
| auto_pre | output | 1 | The access requested auto precharge |
| tgt_bank | output | 2 | Bank of the last ACTIVE, READ, WRITE or PRECHARGE |
| tgt_addr | output | 12 | Address of that command |
| bank_active | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Stored row per bank, bank i at bits i*12 +: 12 |
| mode_reg | output | 12 | Base mode opcode |
| ext_mode_reg | output | 12 | Extended mode opcode |
| pwr_mode | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |
| proto_err | output | 1 | Protocol error pulse |
| cke_err | output | 1 | Access attempted while cke low |

## Verification
The bench uses the default parameters: four banks, a 12-bit address and the precharge modifier on bit 10. With only four banks, random bank addresses collide often. This makes double activation, accesses to closed banks, precharge-all and auto-precharge pile-ups frequent. Clock-enable is driven low on about one edge in ten. Falls therefore happen with banks both open and idle, which reaches both power-down choices, self-refresh refusal and exit edges that carry a command that must be ignored.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [3:0] {
        C_NOP,
        C_ACT,
        C_RD,
        C_WR,
        C_PRE,
        C_REF,
        C_MRS,
        C_BST,
        C_DESEL
    } cmd_e;

    typedef enum logic [1:0] {
        PW_RUN    = 2'd0,
        PW_PRE_PD = 2'd1,
        PW_ACT_PD = 2'd2,
        PW_SELF   = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = C_DESEL;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = C_NOP;
                3'b011: cmd = C_ACT;
                3'b101: cmd = C_RD;
                3'b100: cmd = C_WR;
                3'b010: cmd = C_PRE;
                3'b001: cmd = C_REF;
                3'b000: cmd = C_MRS;
                3'b110: cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              close_req,
    input  logic              ap_req,
    input  logic [ADDR_W-1:0] row_in,
    output logic              is_open,
    output logic [ADDR_W-1:0] row_out
);

    bank_e state_q;
    bank_e state_d;
    logic [ADDR_W-1:0] row_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BK_IDLE && open_req)
                row_q <= row_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (open_req)
                    state_d = BK_OPEN;
            end
            BK_OPEN: begin
                if (close_req)
                    state_d = BK_IDLE;
                else if (ap_req)
                    state_d = BK_CLOSING;
            end
            BK_CLOSING: state_d = BK_IDLE;
            default:    state_d = BK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_open = (state_q != BK_IDLE);
        row_out = row_q;
    end

endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
    import sdram_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic ref_cmd,
    input  logic all_idle,
    output pwr_e state_o,
    output logic run_edge,
    output logic fall_edge
);

    pwr_e state_q;
    pwr_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PW_RUN;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_RUN: begin
                if (!cke) begin
                    if (ref_cmd && all_idle)
                        state_d = PW_SELF;
                    else if (all_idle)
                        state_d = PW_PRE_PD;
                    else
                        state_d = PW_ACT_PD;
                end
            end
            PW_PRE_PD, PW_ACT_PD, PW_SELF: begin
                if (cke)
                    state_d = PW_RUN;
            end
            default: state_d = PW_RUN;
        endcase
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        run_edge  = (state_q == PW_RUN) && cke;
        fall_edge = (state_q == PW_RUN) && !cke;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic                        cmd_act,
    output logic                        cmd_rd,
    output logic                        cmd_wr,
    output logic                        cmd_pre,
    output logic                        cmd_ref,
    output logic                        cmd_mrs,
    output logic                        cmd_bst,
    output logic                        pre_all,
    output logic                        auto_pre,
    output logic [BA_W-1:0]             tgt_bank,
    output logic [ADDR_W-1:0]           tgt_addr,
    output logic [NUM_BANKS-1:0]        bank_active,
    output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
    output logic [ADDR_W-1:0]           mode_reg,
    output logic [ADDR_W-1:0]           ext_mode_reg,
    output logic [1:0]                  pwr_mode,
    output logic                        proto_err,
    output logic                        cke_err
);

    cmd_e cmd;
    pwr_e pwr;
    logic run_edge, fall_edge, all_idle, sel_open, is_rw, ap_flag;
    logic err_act, err_rw, err_sref, err_cke;
    logic do_act, do_rw, do_pre, do_ref, do_mrs, do_bst;
    logic [NUM_BANKS-1:0] bank_open, open_req, close_req, ap_req;
    logic [ADDR_W-1:0]    bank_row [NUM_BANKS];

    sdram_cmd_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_pwr_fsm i_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .ref_cmd   (cmd == C_REF),
        .all_idle  (all_idle),
        .state_o   (pwr),
        .run_edge  (run_edge),
        .fall_edge (fall_edge)
    );

    // command qualification against bank and power state
    always_comb begin
        all_idle = (bank_open == '0);
        sel_open = bank_open[ba];
        is_rw    = (cmd == C_RD) || (cmd == C_WR);
        ap_flag  = addr[AP_BIT];

        err_act  = run_edge && (cmd == C_ACT) && sel_open;
        err_rw   = run_edge && is_rw && !sel_open;
        err_sref = fall_edge && (cmd == C_REF) && !all_idle;
        err_cke  = is_rw && !cke;

        do_act = run_edge && (cmd == C_ACT) && !sel_open;
        do_rw  = run_edge && is_rw && sel_open;
        do_pre = run_edge && (cmd == C_PRE);
        do_ref = (cmd == C_REF) && (run_edge || (fall_edge && all_idle));
        do_mrs = run_edge && (cmd == C_MRS);
        do_bst = run_edge && (cmd == C_BST);
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        always_comb begin
            open_req[i]  = do_act && (ba == BA_W'(i));
            close_req[i] = do_pre && (ap_flag || (ba == BA_W'(i)));
            ap_req[i]    = do_rw && ap_flag && (ba == BA_W'(i));
        end

        sdram_bank_fsm #(
            .ADDR_W (ADDR_W)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[i]),
            .close_req (close_req[i]),
            .ap_req    (ap_req[i]),
            .row_in    (addr),
            .is_open   (bank_open[i]),
            .row_out   (bank_row[i])
        );

        assign open_rows[i*ADDR_W +: ADDR_W] = bank_row[i];
    end

    assign bank_active = bank_open;
    assign pwr_mode    = pwr;

    // registered command reporting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_act      <= 1'b0;
            cmd_rd       <= 1'b0;
            cmd_wr       <= 1'b0;
            cmd_pre      <= 1'b0;
            cmd_ref      <= 1'b0;
            cmd_mrs      <= 1'b0;
            cmd_bst      <= 1'b0;
            pre_all      <= 1'b0;
            auto_pre     <= 1'b0;
            tgt_bank     <= '0;
            tgt_addr     <= '0;
            mode_reg     <= '0;
            ext_mode_reg <= '0;
            proto_err    <= 1'b0;
            cke_err      <= 1'b0;
        end else begin
            cmd_act   <= do_act;
            cmd_rd    <= do_rw && (cmd == C_RD);
            cmd_wr    <= do_rw && (cmd == C_WR);
            cmd_pre   <= do_pre;
            cmd_ref   <= do_ref;
            cmd_mrs   <= do_mrs;
            cmd_bst   <= do_bst;
            pre_all   <= do_pre && ap_flag;
            auto_pre  <= do_rw && ap_flag;
            proto_err <= err_act || err_rw || err_sref;
            cke_err   <= err_cke;
            if (do_act || do_rw || do_pre) begin
                tgt_bank <= ba;
                tgt_addr <= addr;
            end
            if (do_mrs && (ba == BA_W'(0)))
                mode_reg <= addr;
            if (do_mrs && (ba == BA_W'(1)))
                ext_mode_reg <= addr;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
    import sdram_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 cke,
    input logic [BA_W-1:0]      ba,
    input logic                 addr_ap,
    input logic                 cmd_act,
    input logic                 cmd_rd,
    input logic                 cmd_wr,
    input logic                 cmd_pre,
    input logic                 cmd_ref,
    input logic                 cmd_mrs,
    input logic                 cmd_bst,
    input logic                 auto_pre,
    input logic [BA_W-1:0]      tgt_bank,
    input logic [NUM_BANKS-1:0] bank_active,
    input logic [ADDR_W-1:0]    mode_reg,
    input logic [ADDR_W-1:0]    ext_mode_reg,
    input logic [1:0]           pwr_mode,
    input logic                 proto_err,
    input logic                 cke_err
);

    logic run, any_strobe, is_act, is_rw, is_pre_all;

    always_comb begin
        run        = (pwr_mode == PW_RUN) && cke;
        any_strobe = cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs | cmd_bst;
        is_act     = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
        is_rw      = !cs_n && ras_n && !cas_n;
        is_pre_all = !cs_n && ({ras_n, cas_n, we_n} == 3'b010) && addr_ap;
    end

    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !any_strobe && !proto_err && !cke_err
                 && $stable(mode_reg) && $stable(ext_mode_reg));

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst}));

    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_act && !bank_active[ba])
        |=> cmd_act && bank_active[$past(ba)] && (tgt_bank == $past(ba)));

    a_r4_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_pre_all) |=> (bank_active == '0));

    a_r5_ap_retires: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd || cmd_wr) && auto_pre) |=> !bank_active[$past(tgt_bank)]);

    a_r7_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_mode == PW_RUN) && !cke && (bank_active == '0))
        |=> (pwr_mode == PW_PRE_PD) || (pwr_mode == PW_SELF));

    a_r7_open_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_mode == PW_RUN) && !cke && (bank_active != '0))
        |=> (pwr_mode == PW_ACT_PD));

    a_r9_rw_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && is_rw) |=> cke_err && !cmd_rd && !cmd_wr);

    a_r9_low_power_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_mode != PW_RUN) && !cke) |=> !any_strobe);

    a_r10_rw_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_rw && !bank_active[ba]) |=> proto_err && !cmd_rd && !cmd_wr);

    a_r10_act_open: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_act && bank_active[ba]) |=> proto_err && !cmd_act);

    a_r11_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_mode != PW_RUN) && cke) |=> (pwr_mode == PW_RUN) && !any_strobe);

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .cke          (cke),
    .ba           (ba),
    .addr_ap      (addr[AP_BIT]),
    .cmd_act      (cmd_act),
    .cmd_rd       (cmd_rd),
    .cmd_wr       (cmd_wr),
    .cmd_pre      (cmd_pre),
    .cmd_ref      (cmd_ref),
    .cmd_mrs      (cmd_mrs),
    .cmd_bst      (cmd_bst),
    .auto_pre     (auto_pre),
    .tgt_bank     (tgt_bank),
    .bank_active  (bank_active),
    .mode_reg     (mode_reg),
    .ext_mode_reg (ext_mode_reg),
    .pwr_mode     (pwr_mode),
    .proto_err    (proto_err),
    .cke_err      (cke_err)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;

    localparam int NB = 4;
    localparam int AW = 12;

    localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                           K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000, K_BST = 3'b110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0] ba = '0;
    logic [AW-1:0] addr = '0;
    logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst, pre_all, auto_pre;
    logic [1:0] tgt_bank;
    logic [AW-1:0] tgt_addr, mode_reg, ext_mode_reg;
    logic [NB-1:0] bank_active;
    logic [NB*AW-1:0] open_rows;
    logic [1:0] pwr_mode;
    logic proto_err, cke_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 open, 2 closing
    int mb [NB];
    logic [AW-1:0] mrow [NB];
    int mp;
    logic [AW-1:0] mm, me;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
        .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_bst(cmd_bst),
        .pre_all(pre_all), .auto_pre(auto_pre), .tgt_bank(tgt_bank), .tgt_addr(tgt_addr),
        .bank_active(bank_active), .open_rows(open_rows), .mode_reg(mode_reg),
        .ext_mode_reg(ext_mode_reg), .pwr_mode(pwr_mode),
        .proto_err(proto_err), .cke_err(cke_err)
    );

    function automatic int next_pwr(int cur, logic ck, logic sref, logic idle);
        if (cur != 0) return ck ? 0 : cur;
        if (ck) return 0;
        if (sref && idle) return 3;
        return idle ? 1 : 2;
    endfunction

    function automatic logic [NB-1:0] model_active();
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i] = (mb[i] != 0);
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(logic csn, logic [2:0] rcw, logic ck, logic [1:0] b, logic [AW-1:0] a);
        logic exec, fall, idle, isrw, s_act, s_rd, s_wr, s_pre, s_ref, s_mrs, s_bst;
        logic e_ck, e_pr;
        logic [63:0] exp, got;
        string tag;
        cs_n = csn; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = b; addr = a;

        exec = (mp == 0) && ck;
        fall = (mp == 0) && !ck;
        idle = (model_active() == '0);
        isrw = !csn && (rcw == K_RD || rcw == K_WR);
        s_act = exec && !csn && rcw == K_ACT && mb[b] == 0;
        s_rd  = exec && !csn && rcw == K_RD && mb[b] != 0;
        s_wr  = exec && !csn && rcw == K_WR && mb[b] != 0;
        s_pre = exec && !csn && rcw == K_PRE;
        s_ref = !csn && rcw == K_REF && (exec || (fall && idle));
        s_mrs = exec && !csn && rcw == K_MRS;
        s_bst = exec && !csn && rcw == K_BST;
        e_ck  = isrw && !ck;
        e_pr  = (exec && !csn && rcw == K_ACT && mb[b] != 0) ||
                (exec && isrw && mb[b] == 0) ||
                (fall && !csn && rcw == K_REF && !idle);

        if (e_ck)                                  tag = "R9";
        else if (fall && !csn && rcw == K_REF)     tag = "R8";
        else if (e_pr)                             tag = "R10";
        else if (mp != 0)                          tag = "R11";
        else if (fall)                             tag = "R7";
        else if (csn)                              tag = "R1";
        else if (s_act)                            tag = "R3";
        else if ((s_rd || s_wr) && a[10])          tag = "R5";
        else if (s_pre)                            tag = "R4";
        else if (s_mrs)                            tag = "R6";
        else                                       tag = "R2";

        // model update for this edge
        for (int i = 0; i < NB; i++) begin
            int nb;
            nb = (mb[i] == 2) ? 0 : mb[i];
            if (s_act && b == 2'(i)) begin nb = 1; mrow[i] = a; end
            if (s_pre && (a[10] || b == 2'(i))) nb = 0;
            if ((s_rd || s_wr) && a[10] && b == 2'(i) && mb[i] == 1) nb = 2;
            mb[i] = nb;
        end
        mp = next_pwr(mp, ck, !csn && rcw == K_REF, idle);
        if (s_mrs && b == 2'd0) mm = a;
        if (s_mrs && b == 2'd1) me = a;

        @(negedge clk);
        exp = {23'd0, s_act, s_rd, s_wr, s_pre, s_ref, s_mrs, s_bst,
               s_pre && a[10], (s_rd || s_wr) && a[10], e_pr, e_ck,
               model_active(), 2'(mp), mm, me};
        got = {23'd0, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst,
               pre_all, auto_pre, proto_err, cke_err,
               bank_active, pwr_mode, mode_reg, ext_mode_reg};
        check(tag, got, exp);
        if (s_act || s_rd || s_wr)
            check(tag, {50'd0, tgt_bank, tgt_addr}, {50'd0, b, a});
        for (int i = 0; i < NB; i++)
            if (mb[i] == 1) check("R3", 64'(open_rows[i*AW +: AW]), 64'(mrow[i]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240917);
        for (int i = 0; i < NB; i++) begin mb[i] = 0; mrow[i] = '0; end
        mp = 0; mm = '0; me = '0;
        cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; cke = 1'b1;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {20'd0, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst,
                      pre_all, auto_pre, proto_err, cke_err, bank_active, pwr_mode,
                      mode_reg, ext_mode_reg}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        step(1'b1, K_ACT, 1'b1, 2'd0, 12'h123);      // R1 deselected ACTIVE ignored
        step(1'b1, K_MRS, 1'b1, 2'd0, 12'hABC);      // R1 deselected mode load ignored
        step(1'b0, K_ACT, 1'b1, 2'd0, 12'h155);      // R3 open bank 0
        step(1'b0, K_ACT, 1'b1, 2'd0, 12'h2AA);      // R10 double activate
        step(1'b0, K_RD,  1'b1, 2'd1, 12'h010);      // R10 read idle bank
        step(1'b0, K_RD,  1'b1, 2'd0, 12'h010);      // R2 read no auto precharge
        step(1'b0, K_WR,  1'b1, 2'd0, 12'h410);      // R5 write with auto precharge
        step(1'b0, K_NOP, 1'b1, 2'd0, 12'h000);      // R5 bank now idle
        step(1'b0, K_ACT, 1'b1, 2'd1, 12'h0F1);
        step(1'b0, K_ACT, 1'b1, 2'd2, 12'h0F2);
        step(1'b0, K_PRE, 1'b1, 2'd1, 12'h000);      // R4 single precharge
        step(1'b0, K_ACT, 1'b1, 2'd3, 12'h0F3);
        step(1'b0, K_PRE, 1'b1, 2'd0, 12'h400);      // R4 precharge all
        step(1'b0, K_MRS, 1'b1, 2'd0, 12'h321);      // R6 base
        step(1'b0, K_MRS, 1'b1, 2'd1, 12'h654);      // R6 extended
        step(1'b0, K_MRS, 1'b1, 2'd2, 12'hFFF);      // R6 reserved select
        step(1'b0, K_BST, 1'b1, 2'd0, 12'h000);      // R2 burst stop
        step(1'b0, K_REF, 1'b1, 2'd0, 12'h000);      // R2 auto refresh
        step(1'b0, K_NOP, 1'b0, 2'd0, 12'h000);      // R7 precharge power-down
        step(1'b0, K_RD,  1'b0, 2'd0, 12'h000);      // R9 read in power-down
        step(1'b0, K_ACT, 1'b1, 2'd0, 12'h777);      // R11 exit, ACTIVE ignored
        step(1'b0, K_ACT, 1'b1, 2'd0, 12'h777);
        step(1'b0, K_WR,  1'b0, 2'd0, 12'h000);      // R9 write on falling edge
        step(1'b0, K_NOP, 1'b1, 2'd0, 12'h000);      // R11 exit active power-down
        step(1'b0, K_REF, 1'b0, 2'd0, 12'h000);      // R8 self refresh refused
        step(1'b0, K_NOP, 1'b1, 2'd0, 12'h000);
        step(1'b0, K_PRE, 1'b1, 2'd0, 12'h400);
        step(1'b0, K_REF, 1'b0, 2'd0, 12'h000);      // R8 self refresh entry
        step(1'b0, K_NOP, 1'b0, 2'd0, 12'h000);
        step(1'b0, K_NOP, 1'b1, 2'd0, 12'h000);      // R11 exit self refresh

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic csn;
            logic [2:0] rcw;
            csn = ($urandom % 8) == 0;
            rcw = 3'($urandom % 8);
            step(csn, rcw, ($urandom % 10) != 0, 2'($urandom % 4), 12'($urandom));
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule